// File: doc/BRIEF.md
# Chainable 16-bit Serial Command Slave

This block is the serial command port of a gauge motor driver. A host frames each transfer with an active-low select line. While the line is low, the block takes in command bits on each falling edge of the serial clock, most significant bit first. On each rising edge it shifts out one bit. The first sixteen bits out are a status word, captured when the select line falls. After those sixteen, the block sends out the bits it has received, in the order they arrived. Several such slaves can therefore be wired in a chain, with each data-out feeding the next data-in.

The block takes no action from a frame until the select line rises. At that point it checks the frame length. If the frame held a non-zero whole multiple of sixteen bits, the block emits a one-cycle write strobe. The strobe carries the last sixteen bits received: the top four bits as a register address and the remaining twelve as data. Any other frame is dropped. The serial clock, select and data-in pass through two-flop synchronisers into the system clock domain, and all edge detection happens there.

Top module: `daisy_spi_slave`

## Requirements
- R1: While rst_n is low and afterwards until a frame begins, wr_stb is 0 and sdo_oe is 0.
- R2: sdo_oe is 1 only while the synchronised cs_n is low. It is 1 at every rising serial clock edge of a frame.
- R3: sdi is sampled on each falling sclk edge of a frame, most significant bit first. A committed word places its bits 15:12 on wr_addr and its bits 11:0 on wr_data.
- R4: status_in is captured when cs_n falls. The first 16 rising sclk edges present its bits on sdo, from bit 15 down to bit 0.
- R5: From rising edge 17 onward, sdo presents the bits received on sdi, in the order they were received (delayed by 16 bits).
- R6: When cs_n rises after a valid frame, wr_stb is high for exactly one system clock. The strobe carries the last 16 bits received.
- R7: A frame of zero bits, or of a bit count that is not a multiple of 16, produces no wr_stb.
- R8: While cs_n is high, toggling sclk and sdi produces no strobe and leaves sdo_oe at 0.
- R9: A last falling sclk edge detected in the same system cycle as the rising edge of cs_n still counts as a received bit and is included in the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| status_in | input | 16 | Parallel status word to be shifted out |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (high-impedance when 0) |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Target register address |
| wr_data | output | 12 | Write data |

## Verification
The case of interest is a final bit shift and the frame commit landing in the same system cycle. The bench provokes it by lowering sclk and raising cs_n at the same instant. Both lines travel through identical synchronisers, so the falling clock edge and the rising select edge are detected together. The scoreboard expects a strobe whose word includes that last bit. A commit that used the unshifted register would give a different address and data, and a commit that missed the bit count would give no strobe at all.

// File: rtl/daisy_spi_slave.sv
module daisy_spi_slave #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  input  logic [W-1:0]  status_in,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [W-AW-1:0] wr_data
);

  localparam int DW = W - AW;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic sclk_m, sclk_s, sclk_q;
  logic cs_m, cs_s, cs_q;
  logic sdi_m, sdi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {sclk_m, sclk_s, sclk_q} <= '0;
      {cs_m, cs_s, cs_q}       <= '1;
      {sdi_m, sdi_s}           <= '0;
    end else begin
      sclk_m <= sclk;  sclk_s <= sclk_m;  sclk_q <= sclk_s;
      cs_m   <= cs_n;  cs_s   <= cs_m;    cs_q   <= cs_s;
      sdi_m  <= sdi;   sdi_s  <= sdi_m;
    end

  wire cs_fall   = ~cs_s &  cs_q;
  wire cs_rise   =  cs_s & ~cs_q;
  wire sclk_rise =  sclk_s & ~sclk_q & ~cs_q;
  wire sclk_fall = ~sclk_s &  sclk_q & ~cs_q;

  logic [W-1:0]  shreg;
  logic [CW-1:0] bmod;
  logic          seen, out_bit;

  wire [W-1:0]  nxt_sh   = sclk_fall ? {shreg[W-2:0], sdi_s} : shreg;
  wire [CW-1:0] nxt_bmod = !sclk_fall ? bmod : (bmod == LAST) ? '0 : bmod + 1'b1;
  wire          nxt_seen = seen | sclk_fall;
  wire          commit   = cs_rise & nxt_seen & (nxt_bmod == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      bmod    <= '0;
      seen    <= 1'b0;
      out_bit <= 1'b0;
    end else if (cs_fall) begin
      shreg   <= status_in;
      bmod    <= '0;
      seen    <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      shreg <= nxt_sh;
      bmod  <= nxt_bmod;
      seen  <= nxt_seen;
      if (sclk_rise) out_bit <= shreg[W-1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= commit;
      if (commit) begin
        wr_addr <= nxt_sh[W-1 -: AW];
        wr_data <= nxt_sh[DW-1:0];
      end
    end

  assign sdo    = out_bit;
  assign sdo_oe = ~cs_q;

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r6_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !sdo_oe);

  a_r8_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && $past(cs_q)) |-> $stable(out_bit));

  a_r4_status_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (shreg == $past(status_in)));

  a_r3_bit_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && !cs_rise) |=> seen);

  a_r2_oe_off_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_q) |=> !sdo_oe);

endmodule

// File: tb/sim_daisy_spi_slave.sv
module sim_daisy_spi_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdi = 0;
  logic [15:0] status_in = '0;
  logic sdo, sdo_oe, wr_stb;
  logic [3:0] wr_addr;
  logic [11:0] wr_data;

  int checks = 0, fails = 0, stb_cnt = 0;
  bit done = 0;
  logic [15:0] expq[$];

  daisy_spi_slave u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .status_in(status_in), .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && wr_stb) begin
    stb_cnt++;
    if (expq.size() == 0) chk(0, "R6/R7 unexpected strobe", {wr_addr, wr_data}, 0);
    else begin
      logic [15:0] e;
      e = expq.pop_front();
      chk({wr_addr, wr_data} == e, "R3/R6 write word", {wr_addr, wr_data}, e);
    end
  end

  task automatic frame(input int n, input logic [63:0] w, input logic [15:0] st, input bit tight);
    logic exp_o;
    status_in = st;
    if (n > 0 && n % 16 == 0) expq.push_back(w[15:0]);
    cs_n = 0;
    waitn(HALF);
    for (int i = 0; i < n; i++) begin
      sclk = 1;
      sdi  = w[n-1-i];
      waitn(HALF);
      exp_o = (i < 16) ? st[15-i] : w[n-1-(i-16)];
      chk(sdo_oe == 1, "R2 enable in frame", sdo_oe, 1);
      chk(sdo == exp_o, (i < 16) ? "R4 status bit" : "R5 chained bit", sdo, exp_o);
      sclk = 0;
      if (tight && i == n-1) cs_n = 1;
      else waitn(HALF);
    end
    cs_n = 1;
    waitn(12);
    chk(sdo_oe == 0, "R2 enable off after close", sdo_oe, 0);
  endtask

  initial begin
    int s0;
    waitn(3);
    chk(wr_stb == 0 && sdo_oe == 0, "R1 reset state", {wr_stb, sdo_oe}, 0);
    rst_n = 1;
    waitn(4);
    chk(wr_stb == 0 && sdo_oe == 0, "R1 idle after reset", {wr_stb, sdo_oe}, 0);

    frame(16, 64'hA5C3, 16'h1234, 0);
    frame(16, 64'h0FFF, 16'hFFFF, 0);
    frame(32, 64'hDEAD_BEEF, 16'h8001, 0);

    s0 = stb_cnt;
    frame(15, 64'h7ABC, 16'h5555, 0);
    chk(stb_cnt == s0, "R7 15-bit frame dropped", stb_cnt - s0, 0);

    s0 = stb_cnt;
    frame(0, 64'h0, 16'h0, 0);
    chk(stb_cnt == s0, "R7 empty frame dropped", stb_cnt - s0, 0);

    s0 = stb_cnt;
    for (int k = 0; k < 6; k++) begin
      sclk = 1; sdi = k[0]; waitn(HALF);
      chk(sdo_oe == 0, "R8 idle enable", sdo_oe, 0);
      sclk = 0; waitn(HALF);
    end
    chk(stb_cnt == s0, "R8 idle toggles ignored", stb_cnt - s0, 0);

    s0 = stb_cnt;
    frame(16, 64'h3C5A, 16'hC3A5, 1);
    chk(stb_cnt == s0 + 1, "R9 same-cycle close commits", stb_cnt - s0, 1);

    frame(48, 64'h1111_2222_9876, 16'h0F0F, 0);
    waitn(10);
    chk(expq.size() == 0, "R6 all writes seen", expq.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule